// File: doc/BRIEF.md
# Packed Decimal Arithmetic and Digit Conversion Unit

This unit works on decimal digits held four bits apiece. It can add two packed decimal bytes, subtract one from another, or negate one. Each of these three operations also takes in an extend bit, so a value spanning several bytes can be processed one byte after another: the borrow or carry from one byte feeds the next byte through the extend input. It can also convert between two layouts. In the unpacked layout each digit sits in the low nibble of its own byte. In the packed layout the digits are adjacent nibbles. Both conversions add a caller-supplied constant to the unpacked side, which turns character codes into digits or digits into character codes in the same step.

A caller presents one operation per cycle with `in_valid`. The result and the updated flags appear on the registered outputs one cycle later. The zero flag behaves in a sticky way across a chain of bytes. It starts set, any nonzero byte clears it, and a zero byte leaves it as it was. After the last byte it therefore tells whether the whole multi-byte result is zero. The digit count is a parameter, and the default is two digits.

Top module: `bcd_pack_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `out_result`, `out_x`, `out_c` and `out_z` are all 0.
- R2: Each operation presented with `in_valid` high gives `out_valid` high with its result exactly one clock later. A cycle with `in_valid` low gives `out_valid` low on the next cycle.
- R3: Operation code 0 (add) returns, in the low 4*DIGITS bits, the packed decimal value of (src + dst + x) mod 10^DIGITS. Only the low 4*DIGITS bits of `in_src` are used, and the upper bits of the result are zero.
- R4: Operation code 1 (subtract) returns the packed decimal value of (dst − src − x) mod 10^DIGITS. The upper bits of the result are zero.
- R5: Operation code 2 (negate) returns the packed decimal value of (0 − dst − x) mod 10^DIGITS. `in_src` is ignored.
- R6: For codes 0 to 2, `out_x` and `out_c` both equal the decimal carry out (the sum reached 10^DIGITS) or the decimal borrow out (the difference was negative).
- R7: For codes 0 to 2, `out_z` is 0 when the result is nonzero and equals `in_z` when the result is zero.
- R8: Operation code 3 (pack) adds `in_adj` to `in_src` modulo 2^(8*DIGITS). Result digit i is taken from bits 8i+3..8i of that sum, digit 0 being the least significant nibble. The upper half of the result is zero.
- R9: Operation code 4 (unpack) places nibble i of `in_src` into bits 8i+3..8i and clears all other bits. It then adds `in_adj` modulo 2^(8*DIGITS).
- R10: For codes 3 and 4, `out_x`, `out_c` and `out_z` equal `in_x`, `in_c` and `in_z`.
- R11: Codes 5, 6 and 7 return a zero result, and the flags pass through as in R10.
- R12: While `in_valid` is low, `out_result` and the flag outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0 add, 1 subtract, 2 negate, 3 pack, 4 unpack) |
| in_src | input | 8*DIGITS | Source: unpacked digits, or packed operand in low half |
| in_dst | input | 4*DIGITS | Destination packed operand |
| in_adj | input | 8*DIGITS | Adjustment constant for pack and unpack |
| in_x | input | 1 | Extend flag in |
| in_c | input | 1 | Carry flag in |
| in_z | input | 1 | Zero flag in |
| out_valid | output | 1 | Result valid |
| out_result | output | 8*DIGITS | Result |
| out_x | output | 1 | Extend flag out |
| out_c | output | 1 | Carry flag out |
| out_z | output | 1 | Zero flag out |

## Verification
The bench builds the unit with DIGITS = 2. With that setting the full decimal space can be covered. Add, subtract and negate are run on all 10,000 valid operand pairs with the extend bit both clear and set. Because of this, every digit carry and borrow, the wrap at 99 and at 00, and the case where the zero flag keeps its input value are all exercised. Pack and unpack are run on every nibble pair under several adjustment constants. The constants include character-code offsets and values that carry across nibble and byte boundaries.

// File: rtl/bcd_pack_pkg.sv
package bcd_pack_pkg;

    typedef enum logic [2:0] {
        BOP_ADD  = 3'd0,
        BOP_SUB  = 3'd1,
        BOP_NEG  = 3'd2,
        BOP_PACK = 3'd3,
        BOP_UNPK = 3'd4
    } bcd_op_e;

    typedef struct packed {
        logic [3:0] digit;
        logic       carry;
    } digit_step_t;

    typedef struct packed {
        logic x;
        logic c;
        logic z;
    } bcd_flags_t;

    // One decimal digit of a sum with incoming carry; corrects by +6 past nine.
    function automatic digit_step_t dec_add_digit(input logic [3:0] a,
                                                  input logic [3:0] b,
                                                  input logic       ci);
        digit_step_t r;
        logic [4:0]  t;
        t = {1'b0, a} + {1'b0, b} + {4'b0, ci};
        if (t > 5'd9) begin
            r.digit = t[3:0] + 4'd6;
            r.carry = 1'b1;
        end else begin
            r.digit = t[3:0];
            r.carry = 1'b0;
        end
        return r;
    endfunction

    // One decimal digit of a difference with incoming borrow; corrects by -6 on borrow.
    function automatic digit_step_t dec_sub_digit(input logic [3:0] a,
                                                  input logic [3:0] b,
                                                  input logic       bi);
        digit_step_t r;
        logic [4:0]  t;
        t = {1'b0, a} - {1'b0, b} - {4'b0, bi};
        if (t[4]) begin
            r.digit = t[3:0] - 4'd6;
            r.carry = 1'b1;
        end else begin
            r.digit = t[3:0];
            r.carry = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
    import bcd_pack_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                  sub_mode,
    input  logic [4*DIGITS-1:0]   opa,
    input  logic [4*DIGITS-1:0]   opb,
    input  logic                  cin,
    output logic [4*DIGITS-1:0]   sum,
    output logic                  cout
);
    logic [DIGITS:0] chain;

    assign chain[0] = cin;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        digit_step_t st;
        always_comb begin
            if (sub_mode)
                st = dec_sub_digit(opa[4*gi +: 4], opb[4*gi +: 4], chain[gi]);
            else
                st = dec_add_digit(opa[4*gi +: 4], opb[4*gi +: 4], chain[gi]);
        end
        assign sum[4*gi +: 4] = st.digit;
        assign chain[gi+1]    = st.carry;
    end

    assign cout = chain[DIGITS];

endmodule

// File: rtl/bcd_pack_conv.sv
module bcd_pack_conv #(
    parameter int DIGITS = 2
) (
    input  logic [8*DIGITS-1:0] src,
    input  logic [8*DIGITS-1:0] adj,
    output logic [4*DIGITS-1:0] pk_out,
    output logic [8*DIGITS-1:0] unpk_out
);
    localparam int UW = 8 * DIGITS;

    logic [UW-1:0] adjusted;
    logic [UW-1:0] spread;

    assign adjusted = src + adj;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_lane
        assign pk_out[4*gi +: 4] = adjusted[8*gi +: 4];
        assign spread[8*gi +: 8] = {4'b0000, src[4*gi +: 4]};
    end

    assign unpk_out = spread + adj;

endmodule

// File: rtl/bcd_pack_unit.sv
module bcd_pack_unit
    import bcd_pack_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic [8*DIGITS-1:0]   in_src,
    input  logic [4*DIGITS-1:0]   in_dst,
    input  logic [8*DIGITS-1:0]   in_adj,
    input  logic                  in_x,
    input  logic                  in_c,
    input  logic                  in_z,
    output logic                  out_valid,
    output logic [8*DIGITS-1:0]   out_result,
    output logic                  out_x,
    output logic                  out_c,
    output logic                  out_z
);
    localparam int PW = 4 * DIGITS;
    localparam int UW = 8 * DIGITS;

    bcd_op_e     op;
    logic        is_arith;
    logic        sub_mode;
    logic [PW-1:0] opa, opb, dsum;
    logic        dcarry;
    logic [PW-1:0] pk_val;
    logic [UW-1:0] unpk_val;
    logic [UW-1:0] nxt_result;
    bcd_flags_t  nxt_flags;
    bcd_flags_t  in_flags;

    logic          r_valid;
    logic [UW-1:0] r_result;
    bcd_flags_t    r_flags;

    assign op       = bcd_op_e'(in_op);
    assign is_arith = (op == BOP_ADD) || (op == BOP_SUB) || (op == BOP_NEG);
    assign sub_mode = (op == BOP_SUB) || (op == BOP_NEG);
    assign in_flags = '{x: in_x, c: in_c, z: in_z};

    always_comb begin
        unique case (op)
            BOP_ADD: begin opa = in_src[PW-1:0]; opb = in_dst;          end
            BOP_SUB: begin opa = in_dst;          opb = in_src[PW-1:0]; end
            default: begin opa = '0;              opb = in_dst;          end
        endcase
    end

    bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
        .sub_mode (sub_mode),
        .opa      (opa),
        .opb      (opb),
        .cin      (in_x),
        .sum      (dsum),
        .cout     (dcarry)
    );

    bcd_pack_conv #(.DIGITS(DIGITS)) u_conv (
        .src      (in_src),
        .adj      (in_adj),
        .pk_out   (pk_val),
        .unpk_out (unpk_val)
    );

    always_comb begin
        nxt_flags = in_flags;
        case (op)
            BOP_ADD, BOP_SUB, BOP_NEG: begin
                nxt_result  = UW'(dsum);
                nxt_flags.x = dcarry;
                nxt_flags.c = dcarry;
                nxt_flags.z = (dsum != '0) ? 1'b0 : in_z;
            end
            BOP_PACK: nxt_result = UW'(pk_val);
            BOP_UNPK: nxt_result = unpk_val;
            default:  nxt_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid  <= 1'b0;
            r_result <= '0;
            r_flags  <= '0;
        end else begin
            r_valid <= in_valid;
            if (in_valid) begin
                r_result <= nxt_result;
                r_flags  <= nxt_flags;
            end
        end
    end

    assign out_valid  = r_valid;
    assign out_result = r_result;
    assign out_x      = r_flags.x;
    assign out_c      = r_flags.c;
    assign out_z      = r_flags.z;

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_arith) |=> (out_result[UW-1:PW] == '0));

    assert_xc_agree_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_arith) |=> (out_x == out_c));

    assert_zero_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_arith) |=>
            ((out_result != '0) ? !out_z : (out_z == $past(in_z))));

    assert_flags_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_arith) |=>
            (out_x == $past(in_x) && out_c == $past(in_c) && out_z == $past(in_z)));

    assert_bad_op_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > 3'd4) |=> (out_result == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_valid) |=> ($stable(out_result) && $stable(out_z)));

endmodule

// File: tb/test_bcd_pack_unit.sv
module test_bcd_pack_unit;
    localparam int DIGITS = 2;
    localparam int UW = 8 * DIGITS;
    localparam int PW = 4 * DIGITS;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [2:0]    in_op;
    logic [UW-1:0] in_src;
    logic [PW-1:0] in_dst;
    logic [UW-1:0] in_adj;
    logic          in_x, in_c, in_z;
    logic          out_valid;
    logic [UW-1:0] out_result;
    logic          out_x, out_c, out_z;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bcd_pack_unit #(.DIGITS(DIGITS)) i_bcd_pack_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .in_dst(in_dst), .in_adj(in_adj),
        .in_x(in_x), .in_c(in_c), .in_z(in_z),
        .out_valid(out_valid), .out_result(out_result),
        .out_x(out_x), .out_c(out_c), .out_z(out_z)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic check(input string req, input logic ev, input logic [UW-1:0] er,
                         input logic ex, input logic ec, input logic ez);
        checks++;
        if (out_valid !== ev || out_result !== er || out_x !== ex ||
            out_c !== ec || out_z !== ez) begin
            failures++;
            $display("FAIL %s: got v=%b r=%h x=%b c=%b z=%b, expected v=%b r=%h x=%b c=%b z=%b",
                     req, out_valid, out_result, out_x, out_c, out_z, ev, er, ex, ec, ez);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one register stage).
    task automatic issue(input logic [2:0] op, input logic [UW-1:0] s, input logic [PW-1:0] d,
                         input logic [UW-1:0] a, input logic x, input logic c, input logic z);
        in_valid = 1'b1; in_op = op; in_src = s; in_dst = d; in_adj = a;
        in_x = x; in_c = c; in_z = z;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_src = '0; in_dst = '0;
        in_adj = '0; in_x = 1'b0; in_c = 1'b0; in_z = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, '0, 1'b0, 1'b0, 1'b0);

        // R3, R4, R5, R6, R7: full decimal sweep of the arithmetic operations
        for (int op = 0; op < 3; op++) begin
            for (int s = 0; s < 100; s++) begin
                for (int d = 0; d < 100; d++) begin
                    for (int x = 0; x < 2; x++) begin
                        int t;
                        int r;
                        logic cy, zi;
                        zi = 1'((s + d + x) % 3 != 0);
                        if (op == 0)      t = s + d + x;
                        else if (op == 1) t = d - s - x;
                        else              t = 0 - d - x;
                        cy = (op == 0) ? (t >= 100) : (t < 0);
                        r  = (t + 100) % 100;
                        issue(3'(op), {8'hA5, to_bcd(s)}, to_bcd(d), 16'h1234,
                              1'(x), ~cy, zi);
                        check(op == 0 ? "R3/R6/R7 add" : (op == 1 ? "R4/R6/R7 sub" : "R5/R6/R7 neg"),
                              1'b1, {8'h00, to_bcd(r)}, cy, cy, (r != 0) ? 1'b0 : zi);
                    end
                end
            end
        end

        // R8 pack and R10 flag pass-through
        for (int k = 0; k < 4; k++) begin
            logic [15:0] adj;
            adj = (k == 0) ? 16'h0000 : (k == 1) ? 16'hD0D0 : (k == 2) ? 16'h0707 : 16'hFFF9;
            for (int v = 0; v < 256; v++) begin
                logic [15:0] src, sum;
                src = {4'(v * 7), 4'(v >> 4), 4'(v * 3), 4'(v)};
                sum = src + adj;
                issue(3'd3, src, 8'h5A, adj, 1'(v), 1'(v >> 1), 1'(v >> 2));
                check("R8/R10 pack", 1'b1, {8'h00, sum[11:8], sum[3:0]},
                      1'(v), 1'(v >> 1), 1'(v >> 2));
            end
        end

        // R9 unpack and R10 flag pass-through
        for (int k = 0; k < 4; k++) begin
            logic [15:0] adj;
            adj = (k == 0) ? 16'h0000 : (k == 1) ? 16'h3030 : (k == 2) ? 16'h00F8 : 16'hFFFF;
            for (int v = 0; v < 256; v++) begin
                int expv;
                expv = ((v >> 4) * 256 + (v % 16) + adj) % 65536;
                issue(3'd4, {8'hC3, 8'(v)}, 8'h99, adj, 1'(v >> 3), 1'(v), 1'(v >> 5));
                check("R9/R10 unpack", 1'b1, 16'(expv), 1'(v >> 3), 1'(v), 1'(v >> 5));
            end
        end

        // R11 unused codes
        for (int op = 5; op < 8; op++) begin
            issue(3'(op), 16'h4321, 8'h55, 16'h1111, 1'b1, 1'b0, 1'b1);
            check("R11 unused op", 1'b1, '0, 1'b1, 1'b0, 1'b1);
        end

        // R2 and R12: a known result, then idle cycles with changing inputs
        issue(3'd0, 16'h0047, 8'h38, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R2 one-cycle result", 1'b1, 16'h0085, 1'b0, 1'b0, 1'b0);
        in_valid = 1'b0; in_op = 3'd0; in_src = 16'h0099; in_dst = 8'h99; in_x = 1'b1; in_z = 1'b1;
        @(negedge clk);
        check("R2/R12 idle hold", 1'b0, 16'h0085, 1'b0, 1'b0, 1'b0);
        in_op = 3'd4; in_src = 16'h00FF;
        @(negedge clk);
        check("R12 idle hold second cycle", 1'b0, 16'h0085, 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule